// File: doc/BRIEF.md
# Decoder Status, Interrupt and Control Registers

This block is the processor-facing register set of a variable-length bitstream decoder. The decoder core sends it one-cycle event pulses: command finished, start code found, bitstream error, input transfer done, header output transfer done, run/level output transfer done and run/level overflow. The block latches each pulse into a sticky status flag. It combines the flags with a per-bit enable mask to drive a single registered interrupt line.

A control register holds the low byte of the most recent slice start code and a two-bit input-done mode. The core loads the slice byte when it sees a new slice, and it does so no later than the interrupt that reports the slice. Software can also load the slice byte by writing with a strobe bit set. A write with the strobe bit clear changes the mode field only. The register port is a simple synchronous one: a write takes effect at the clock edge, and read data appears on the cycle after the read request.

Top module: `vdec_csr`

## Requirements
- R1: A synchronous active-high reset clears the status flags, the enable mask, the slice byte, the mode field, the read data and the interrupt line.
- R2: An event pulse on `hw_evt[i]` sets status bit i, read at offset 0x0. The bit positions are: 0 command done, 1 start code, 2 bitstream error, 3 input done, 4 header output done, 5 run/level output done, 6 run/level overflow.
- R3: Status bits 1 to 6 are cleared by a write to offset 0x0 with a 1 in that bit position. A 0 in a bit position leaves that bit unchanged.
- R4: Status bit 0 ignores writes to offset 0x0 and is cleared only by a `new_cmd` pulse.
- R5: When a set event meets a clear (a write-one-to-clear or `new_cmd`) in the same cycle, the flag ends up set.
- R6: The enable mask at offset 0x4, bits 6:0, is written and read back unchanged. Bits above 6 read as 0.
- R7: `irq` is 1 in the cycle after any status bit and its enable bit are both 1. Otherwise it is 0 in the cycle after.
- R8: A `slice_cap_vld` pulse loads `slice_cap_code` into the slice byte, read at offset 0x8 bits 7:0.
- R9: A write to offset 0x8 with bit 8 set loads bits 7:0 into the slice byte and leaves the mode field unchanged.
- R10: A write to offset 0x8 with bit 8 clear loads bits 10:9 into the mode field and leaves the slice byte unchanged.
- R11: Bit 8 of offset 0x8 always reads as 0.
- R12: When a hardware slice capture and a strobe write occur in the same cycle, the captured byte is the one stored.
- R13: `reg_rdata` shows the register selected by a read on the cycle after `reg_rd`, taken before any write in that same cycle. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| hw_evt | input | 7 | Event pulses from the decoder core, one per status bit |
| new_cmd | input | 1 | Pulse marking the issue of a new command |
| slice_cap_vld | input | 1 | Pulse when the core captures a slice start code |
| slice_cap_code | input | 8 | Low byte of the captured slice start code |
| irq | output | 1 | Registered interrupt line |

## Verification
The assertions check the following on every cycle: each event pulse lands in its flag, the two kinds of clear behave as required, the interrupt line follows the masked flags with one cycle of lag, a hardware capture beats a strobe write, the field that a control write must not touch stays stable, and the strobe bit reads as zero. Some behaviours need the bench's scenarios to show them. One is that a mixed, random stream of events, clears, enable changes and control writes gives read values that match an independent model. Others are directed corners: a write-one-to-clear aimed at the command-done bit, simultaneous set and clear, reads of unmapped offsets, and a read and a write in the same cycle.

// File: rtl/vdec_csr_pkg.sv
`timescale 1ns/1ps
package vdec_csr_pkg;
  // status bit that is cleared by a new command rather than by software
  localparam int FLG_CMD  = 0;
  // register byte offsets
  localparam int OFS_STAT = 0;
  localparam int OFS_IE   = 4;
  localparam int OFS_CTL  = 8;
endpackage

// File: rtl/vdec_flag_bank.sv
`timescale 1ns/1ps
module vdec_flag_bank
  import vdec_csr_pkg::*;
#(
  parameter int NFLAG = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_evt,
  input  logic             w1c_en,
  input  logic [NFLAG-1:0] w1c_mask,
  input  logic             new_cmd,
  output logic [NFLAG-1:0] flags
);

  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    logic q;
    assign flags[i] = q;

    if (i == FLG_CMD) begin : g_cmd
      logic unused_w1c;
      assign unused_w1c = w1c_mask[i];

      always_ff @(posedge clk) begin
        if (rst)             q <= 1'b0;
        else if (set_evt[i]) q <= 1'b1;
        else if (new_cmd)    q <= 1'b0;
      end

      a_r4_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (q && !new_cmd) |=> q);
      a_r5_cmd_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_evt[i] && new_cmd) |=> q);
    end else begin : g_w1c
      always_ff @(posedge clk) begin
        if (rst)                         q <= 1'b0;
        else if (set_evt[i])             q <= 1'b1;
        else if (w1c_en && w1c_mask[i])  q <= 1'b0;
      end

      a_r3_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (w1c_en && w1c_mask[i] && !set_evt[i]) |=> !q);
      a_r3_w1c_holds: assert property (@(posedge clk) disable iff (rst)
        (q && !(w1c_en && w1c_mask[i])) |=> q);
    end

    a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
      set_evt[i] |=> q);
  end

endmodule

// File: rtl/vdec_ctl_reg.sv
`timescale 1ns/1ps
module vdec_ctl_reg #(
  parameter int SLICE_W = 8,
  parameter int MODE_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_strobe,
  input  logic [SLICE_W-1:0] wr_slice,
  input  logic [MODE_W-1:0]  wr_mode,
  input  logic               cap_vld,
  input  logic [SLICE_W-1:0] cap_code,
  output logic [SLICE_W-1:0] slice,
  output logic [MODE_W-1:0]  mode
);

  // slice byte: hardware capture outranks a software strobe write
  always_ff @(posedge clk) begin
    if (rst)                       slice <= '0;
    else if (cap_vld)              slice <= cap_code;
    else if (wr_en && wr_strobe)   slice <= wr_slice;
  end

  // mode field: only a write with the strobe clear touches it
  always_ff @(posedge clk) begin
    if (rst)                       mode <= '0;
    else if (wr_en && !wr_strobe)  mode <= wr_mode;
  end

  a_r12_capture_wins: assert property (@(posedge clk) disable iff (rst)
    cap_vld |=> (slice == $past(cap_code)));
  a_r9_mode_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_strobe) |=> $stable(mode));
  a_r10_slice_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_strobe && !cap_vld) |=> $stable(slice));

endmodule

// File: rtl/vdec_irq_gen.sv
`timescale 1ns/1ps
module vdec_irq_gen #(
  parameter int NFLAG = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] flags,
  input  logic [NFLAG-1:0] ie,
  output logic             irq
);

  logic pending;
  assign pending = |(flags & ie);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= pending;
  end

  a_r7_irq_rises: assert property (@(posedge clk) disable iff (rst)
    (|(flags & ie)) |=> irq);
  a_r7_irq_falls: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & ie)) |=> !irq);

endmodule

// File: rtl/vdec_csr.sv
`timescale 1ns/1ps
module vdec_csr
  import vdec_csr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int NFLAG   = 7,
  parameter int SLICE_W = 8,
  parameter int MODE_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NFLAG-1:0]   hw_evt,
  input  logic               new_cmd,
  input  logic               slice_cap_vld,
  input  logic [SLICE_W-1:0] slice_cap_code,
  output logic               irq
);

  localparam int STB_BIT  = SLICE_W;
  localparam int MODE_LSB = SLICE_W + 1;
  localparam int CTL_TOP  = MODE_LSB + MODE_W;

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(OFS_IE);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);

  logic sel_stat, sel_ie, sel_ctl;
  assign sel_stat = (reg_addr == A_STAT);
  assign sel_ie   = (reg_addr == A_IE);
  assign sel_ctl  = (reg_addr == A_CTL);

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata[DATA_W-1:CTL_TOP];

  logic [NFLAG-1:0]   flags;
  logic [NFLAG-1:0]   ie_q;
  logic [SLICE_W-1:0] slice;
  logic [MODE_W-1:0]  mode;

  vdec_flag_bank #(.NFLAG(NFLAG)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_evt  (hw_evt),
    .w1c_en   (reg_wr && sel_stat),
    .w1c_mask (reg_wdata[NFLAG-1:0]),
    .new_cmd  (new_cmd),
    .flags    (flags)
  );

  always_ff @(posedge clk) begin
    if (rst)                  ie_q <= '0;
    else if (reg_wr && sel_ie) ie_q <= reg_wdata[NFLAG-1:0];
  end

  vdec_ctl_reg #(.SLICE_W(SLICE_W), .MODE_W(MODE_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr && sel_ctl),
    .wr_strobe (reg_wdata[STB_BIT]),
    .wr_slice  (reg_wdata[SLICE_W-1:0]),
    .wr_mode   (reg_wdata[CTL_TOP-1:MODE_LSB]),
    .cap_vld   (slice_cap_vld),
    .cap_code  (slice_cap_code),
    .slice     (slice),
    .mode      (mode)
  );

  vdec_irq_gen #(.NFLAG(NFLAG)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .flags (flags),
    .ie    (ie_q),
    .irq   (irq)
  );

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_stat)     rd_mux = DATA_W'(flags);
    else if (sel_ie)  rd_mux = DATA_W'(ie_q);
    else if (sel_ctl) rd_mux = DATA_W'({mode, 1'b0, slice});
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (reg_rdata == '0 && !irq));
  a_r6_ie_written: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && sel_ie) |=> (ie_q == $past(reg_wdata[NFLAG-1:0])));
  a_r11_strobe_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && sel_ctl) |=> !reg_rdata[STB_BIT]);
  a_r13_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !sel_stat && !sel_ie && !sel_ctl) |=> (reg_rdata == '0));

endmodule

// File: tb/sim_vdec_csr.sv
`timescale 1ns/1ps
module sim_vdec_csr;

  localparam int MAXCYC = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  hw_evt = '0;
  logic        new_cmd = 1'b0;
  logic        slice_cap_vld = 1'b0;
  logic [7:0]  slice_cap_code = '0;
  logic        irq;

  always #4 clk = ~clk;

  vdec_csr u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hw_evt(hw_evt), .new_cmd(new_cmd), .slice_cap_vld(slice_cap_vld),
    .slice_cap_code(slice_cap_code), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model
  logic [6:0] m_flags = '0, m_ie = '0;
  logic [7:0] m_slice = '0;
  logic [1:0] m_mode  = '0;

  function automatic logic [31:0] model_read(logic [3:0] a);
    case (a)
      4'h0:    return {25'd0, m_flags};
      4'h4:    return {25'd0, m_ie};
      4'h8:    return {21'd0, m_mode, 1'b0, m_slice};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_inputs();
    reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    hw_evt = '0; new_cmd = 0; slice_cap_vld = 0; slice_cap_code = '0;
  endtask

  // one clock: inputs already driven; model next state, then compare
  task automatic tick(string tag);
    logic [6:0]  n_flags;
    logic [6:0]  n_ie;
    logic [7:0]  n_slice;
    logic [1:0]  n_mode;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic        was_rd;
    exp_rd  = model_read(reg_addr);
    exp_irq = |(m_flags & m_ie);
    was_rd  = reg_rd;
    n_flags[0] = hw_evt[0] | (m_flags[0] & ~new_cmd);
    for (int i = 1; i < 7; i++)
      n_flags[i] = hw_evt[i] |
        (m_flags[i] & ~(reg_wr && reg_addr == 4'h0 && reg_wdata[i]));
    n_ie = (reg_wr && reg_addr == 4'h4) ? reg_wdata[6:0] : m_ie;
    if (slice_cap_vld)                                   n_slice = slice_cap_code;
    else if (reg_wr && reg_addr == 4'h8 && reg_wdata[8])  n_slice = reg_wdata[7:0];
    else                                                 n_slice = m_slice;
    n_mode = (reg_wr && reg_addr == 4'h8 && !reg_wdata[8]) ? reg_wdata[10:9] : m_mode;
    @(posedge clk);
    m_flags = n_flags; m_ie = n_ie; m_slice = n_slice; m_mode = n_mode;
    @(negedge clk);
    chk("R7 irq", {31'd0, irq}, {31'd0, exp_irq});
    if (was_rd) chk(tag, reg_rdata, exp_rd);
    clear_inputs();
  endtask

  task automatic rd(logic [3:0] a, string tag);
    reg_rd = 1; reg_addr = a; tick(tag);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, string tag);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick(tag);
  endtask

  initial begin
    #(MAXCYC * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", reg_rdata, 32'd0);
    chk("R1 irq in reset", {31'd0, irq}, 32'd0);
    rst = 0;
    rd(4'h0, "R1 status after reset");
    rd(4'h4, "R1 enable after reset");
    rd(4'h8, "R1 control after reset");

    // R4: command-done ignores write-one-to-clear, clears on new_cmd
    hw_evt = 7'h01; tick("R2");
    wr(4'h0, 32'h7F, "R4");
    rd(4'h0, "R4 bit0 survives w1c");
    new_cmd = 1; tick("R4");
    rd(4'h0, "R4 bit0 cleared by new_cmd");

    // R5: set beats clear
    hw_evt = 7'h02; tick("R2");
    hw_evt = 7'h02; reg_wr = 1; reg_addr = 4'h0; reg_wdata = 32'h02; tick("R5");
    hw_evt = 7'h01; new_cmd = 1; tick("R5");
    rd(4'h0, "R5 set wins");
    wr(4'h0, 32'h02, "R3");
    rd(4'h0, "R3 w1c clears bit1 only");

    // R6 / R7
    wr(4'h4, 32'hFFFF_FF84, "R6");
    rd(4'h4, "R6 enable readback");
    hw_evt = 7'h04; tick("R2");
    tick("R7"); tick("R7");
    wr(4'h0, 32'h04, "R7 clear source");
    tick("R7");

    // R8 / R12 / R9 / R10 / R11
    slice_cap_vld = 1; slice_cap_code = 8'hA5; hw_evt = 7'h02; tick("R8");
    rd(4'h8, "R8 captured slice");
    slice_cap_vld = 1; slice_cap_code = 8'h3C;
    reg_wr = 1; reg_addr = 4'h8; reg_wdata = 32'h1C3; tick("R12");
    rd(4'h8, "R12 capture wins");
    wr(4'h8, 32'h755, "R9");
    rd(4'h8, "R9 R11 slice only, strobe reads 0");
    wr(4'h8, 32'h411, "R10");
    rd(4'h8, "R10 mode only");

    // R13: unmapped and same-cycle read/write
    rd(4'hC, "R13 unmapped");
    rd(4'h2, "R13 unmapped");
    reg_rd = 1; reg_wr = 1; reg_addr = 4'h4; reg_wdata = 32'h11; tick("R13 read before write");
    rd(4'h4, "R6 R13 new value");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] ra, wa;
      ra = 4'(4 * $urandom_range(0, 3));
      wa = 4'(4 * $urandom_range(0, 3));
      hw_evt = 7'($urandom & $urandom & $urandom);
      new_cmd = ($urandom_range(0, 7) == 0);
      slice_cap_vld = ($urandom_range(0, 9) == 0);
      slice_cap_code = 8'($urandom);
      if ($urandom_range(0, 2) == 0) begin
        reg_wr = 1; reg_addr = wa; reg_wdata = $urandom;
      end
      if ($urandom_range(0, 1) == 0) begin
        reg_rd = 1; reg_addr = reg_wr ? reg_addr : ra;
      end
      tick("R2 R3 R6 R9 R10 random read");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule